// File: doc/BRIEF.md
# Balanced-Ternary Master-Slave Flip-Flop

This block stores one balanced-ternary digit (trit) and updates it on the rising sweep of a three-level clock. It is made of two level-controlled ternary latches in series. The three-level clock is split into two half-clocks: its lower half, min(C,0), opens the first latch, and its upper half, max(C,0), opens the second. A trit on the data input enters the first latch while the clock sits at -1. It moves on to the output only when the clock later reaches +1. At every other clock level both latches hold, so the output cannot follow the data input directly.

Every ternary signal is a 2-bit code sampled on a binary system clock, and both latches are registers updated on that clock. Each latch has one selector input that its half-clock can never reach. These spare inputs are used for fast initialization: while the init strobe is high, both latches load the same chosen trit in a single cycle. The block also has a synchronous reset. A flag reports whether the output holds a value that was actually captured, because a cell that has only been reset has not yet seen a full clock sweep.

Top module: `trit_msff`

## Requirements
- R1: Trits are coded as 2'b11 = -1, 2'b00 = 0, 2'b01 = +1. Code 2'b10 is illegal. `bad_code` is high in the same cycle whenever `tclk` or `d` carries 2'b10, or `init_en` is high and `init_trit` carries 2'b10.
- R2: At a system-clock edge with `rst` high, the stored first-latch trit and `q` become 0 (2'b00) and `q_known` becomes 0. Reset takes priority over every other input.
- R3: At an edge where `tclk` is -1 and `init_en` is low, the first latch takes `d` if `d` is legal. An illegal `d` leaves the latch unchanged.
- R4: At an edge where `tclk` is +1 and `init_en` is low, `q` takes the trit held in the first latch before that edge.
- R5: A value on `d` reaches `q` only after an edge with `tclk` = -1 is followed later by an edge with `tclk` = +1. While `tclk` stays at 0 or -1, or falls from +1 through 0 to -1, `q` does not change, whatever `d` does.
- R6: An illegal `tclk` code (2'b10) is treated as level 0, so both latches hold.
- R7: At an edge where `init_en` is high and `init_trit` is legal, both the first latch and `q` load `init_trit`, `q_known` becomes 1, and `tclk` is ignored. When `init_en` is high and `init_trit` is illegal, nothing changes.
- R8: `q_known` stays 0 after reset until `q` loads from a first latch that has captured a legal `d`, or until an initialization. Only reset clears it again.
- R9: `q` never shows the illegal code 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all ternary signals |
| rst | input | 1 | Synchronous reset, active high |
| tclk | input | 2 | Three-level clock trit |
| d | input | 2 | Data trit into the first latch |
| init_en | input | 1 | Selects the spare latch inputs for initialization |
| init_trit | input | 2 | Trit loaded into both latches during initialization |
| q | output | 2 | Stored output trit |
| q_known | output | 1 | High once `q` holds a captured or initialized trit |
| bad_code | output | 1 | High while an illegal code is on an active input |

## Verification
The case hardest to reach from the ports is the hold while the ternary clock falls from +1 through 0 to -1. In that sweep the first latch reopens and takes new data, yet the output must not move until the clock climbs back to +1. The stimulus drives exactly that walk while it changes `d` at every level. It also covers a -1 to +1 jump with no 0 sample in between, and it compares a behavioural model every cycle through a long random run. The `q_known` flag after reset is reached only through a full sweep or an initialization. A sweep whose capture saw only illegal data must leave the flag low.

// File: rtl/trit_msff.sv
module trit_msff (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] tclk,
  input  logic [1:0] d,
  input  logic       init_en,
  input  logic [1:0] init_trit,
  output logic [1:0] q,
  output logic       q_known,
  output logic       bad_code
);
  localparam logic [1:0] NEG  = 2'b11;
  localparam logic [1:0] ZERO = 2'b00;
  localparam logic [1:0] POS  = 2'b01;
  localparam logic [1:0] ILL  = 2'b10;

  logic [1:0] lo_clk, hi_clk, m_sel, s_sel;
  logic [1:0] m_q, m_in, s_in;
  logic       m_known, m_load, s_load, s_known_in;

  assign lo_clk = (tclk == NEG) ? NEG : ZERO;
  assign hi_clk = (tclk == POS) ? POS : ZERO;

  assign m_sel = init_en ? POS : lo_clk;
  assign s_sel = init_en ? NEG : hi_clk;

  always_comb begin
    m_in = m_q;
    m_load = 1'b0;
    case (m_sel)
      NEG: begin m_in = d;         m_load = (d != ILL); end
      POS: begin m_in = init_trit; m_load = (init_trit != ILL); end
      default: ;
    endcase
  end

  always_comb begin
    s_in = q;
    s_known_in = q_known;
    s_load = 1'b0;
    case (s_sel)
      POS: begin s_in = m_q;       s_known_in = m_known; s_load = 1'b1; end
      NEG: begin s_in = init_trit; s_known_in = 1'b1;    s_load = (init_trit != ILL); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_q <= ZERO;
      m_known <= 1'b0;
    end else if (m_load) begin
      m_q <= m_in;
      m_known <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= ZERO;
      q_known <= 1'b0;
    end else if (s_load) begin
      q <= s_in;
      q_known <= s_known_in;
    end
  end

  assign bad_code = (tclk == ILL) || (d == ILL) || (init_en && (init_trit == ILL));

  a_r5_hold_off_high: assert property (@(posedge clk) disable iff (rst)
    (!init_en && tclk != POS) |=> $stable(q));

  a_r3_master_capture: assert property (@(posedge clk) disable iff (rst)
    (!init_en && tclk == NEG && d != ILL) |=> (m_q == $past(d)));

  a_r5_two_step: assert property (@(posedge clk) disable iff (rst)
    (!init_en && tclk == NEG && d != ILL) ##1 (!init_en && tclk == POS) |=> (q == $past(d, 2)));

  a_r7_init_load: assert property (@(posedge clk) disable iff (rst)
    (init_en && init_trit != ILL) |=> (q == $past(init_trit) && q_known && m_q == $past(init_trit)));

  a_r8_known_sticky_low: assert property (@(posedge clk) disable iff (rst)
    (!q_known && !init_en && tclk != POS) |=> !q_known);

  a_r9_no_illegal_out: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q != ILL));
endmodule

// File: tb/trit_msff_test.sv
`timescale 1ns/1ps
module trit_msff_test;
  logic clk = 1'b0;
  logic rst, init_en;
  logic [1:0] tclk, d, init_trit;
  logic [1:0] q;
  logic q_known, bad_code;

  int checks = 0, fails = 0;
  int mm, mk, qm, qk;

  always #2.5 clk = ~clk;

  trit_msff uut (.clk(clk), .rst(rst), .tclk(tclk), .d(d), .init_en(init_en),
                 .init_trit(init_trit), .q(q), .q_known(q_known), .bad_code(bad_code));

  function automatic int dec(input logic [1:0] v);
    case (v)
      2'b11: return -1;
      2'b00: return 0;
      2'b01: return 1;
      default: return 2;
    endcase
  endfunction

  function automatic logic [1:0] enc(input int v);
    return (v < 0) ? 2'b11 : (v > 0) ? 2'b01 : 2'b00;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic [1:0] c, input logic [1:0] dv,
                      input logic ie, input logic [1:0] it, input string tag);
    int eb;
    rst = r; tclk = c; d = dv; init_en = ie; init_trit = it;
    #1;
    eb = (dec(c) == 2 || dec(dv) == 2 || (ie && dec(it) == 2)) ? 1 : 0;
    chk("R1 bad_code", int'(bad_code), eb);
    @(posedge clk);
    if (r) begin
      mm = 0; mk = 0; qm = 0; qk = 0;
    end else if (ie) begin
      if (dec(it) != 2) begin mm = dec(it); qm = mm; mk = 1; qk = 1; end
    end else if (dec(c) == 1) begin
      qm = mm; qk = mk;
    end else if (dec(c) == -1 && dec(dv) != 2) begin
      mm = dec(dv); mk = 1;
    end
    @(negedge clk);
    chk({tag, " q"}, int'(q), int'(enc(qm)));
    chk("R8 q_known", int'(q_known), qk);
    chk("R9 legal q", (q == 2'b10) ? 1 : 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog timeout");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    mm = 0; mk = 0; qm = 0; qk = 0;
    rst = 1; tclk = 0; d = 0; init_en = 0; init_trit = 0;
    @(negedge clk);
    step(1, 2'b00, 2'b01, 0, 0, "R2 reset");
    step(1, 2'b01, 2'b11, 1, 2'b01, "R2 reset priority");
    step(0, 2'b00, 2'b01, 0, 0, "R8 idle");
    step(0, 2'b01, 2'b01, 0, 0, "R8 high without capture");
    step(0, 2'b11, 2'b01, 0, 0, "R3 capture +1");
    step(0, 2'b11, 2'b11, 0, 0, "R3 capture -1");
    step(0, 2'b00, 2'b01, 0, 0, "R5 hold at 0");
    step(0, 2'b01, 2'b00, 0, 0, "R4 rise");
    step(0, 2'b01, 2'b01, 0, 0, "R4 stay high");
    step(0, 2'b00, 2'b01, 0, 0, "R5 fall to 0");
    step(0, 2'b11, 2'b01, 0, 0, "R5 fall to -1");
    step(0, 2'b11, 2'b00, 0, 0, "R5 low d change");
    step(0, 2'b00, 2'b11, 0, 0, "R5 mid d change");
    step(0, 2'b01, 2'b11, 0, 0, "R5 rise delivers");
    step(0, 2'b11, 2'b10, 0, 0, "R3 illegal d");
    step(0, 2'b01, 2'b00, 0, 0, "R3 illegal d kept");
    step(0, 2'b11, 2'b01, 0, 0, "R6 capture");
    step(0, 2'b10, 2'b11, 0, 0, "R6 illegal clock");
    step(0, 2'b10, 2'b00, 0, 0, "R6 illegal clock again");
    step(0, 2'b01, 2'b00, 0, 0, "R6 then rise");
    step(0, 2'b11, 2'b00, 0, 0, "R4 direct jump");
    step(0, 2'b01, 2'b00, 0, 0, "R4 direct jump");
    step(1, 2'b00, 2'b00, 0, 0, "R2 reset again");
    step(0, 2'b00, 2'b00, 1, 2'b11, "R7 init -1");
    step(0, 2'b01, 2'b01, 1, 2'b01, "R7 init overrides clock");
    step(0, 2'b11, 2'b00, 1, 2'b10, "R7 illegal init");
    step(0, 2'b01, 2'b00, 0, 0, "R7 master was initialized");
    step(1, 2'b00, 2'b00, 0, 0, "R2 reset third");
    step(0, 2'b11, 2'b10, 0, 0, "R8 only illegal data");
    step(0, 2'b01, 2'b00, 0, 0, "R8 still unknown");
    for (int i = 0; i < 400; i++) begin
      logic [1:0] rc, rd, ri;
      rc = 2'($urandom); rd = 2'($urandom); ri = 2'($urandom);
      step(($urandom % 50) == 0, rc, rd, ($urandom % 8) == 0, ri, "R4 random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule